// File: doc/BRIEF.md
# Interrupt Priority Arbitration Core

This block keeps the per-vector interrupt state of a processor-local interrupt controller for 256 vectors. It holds three bit arrays: pending requests, vectors in service, and the trigger mode each pending vector arrived with. Vectors arrive on a one-cycle delivery strobe, tagged edge or level. The block compares the highest pending vector against a processor priority. That priority comes from the task priority register and the highest vector in service, compared by 16-vector class (the upper nibble of the vector number). When the pending vector is allowed through, the block raises a request line to the core.

The core answers with an acknowledge handshake. A small two-state machine serves it. `ACK_IDLE` waits for `ack_req`. If a request is seen, it moves to `ACK_RESP` and decides the outcome in the same step:
- "no vector" when the controller is disabled or nothing is pending;
- the spurious vector when the task priority blocks the pending vector;
- otherwise the pending vector, which moves from pending to in service.

`ACK_RESP` presents the result for one cycle and always returns to `ACK_IDLE`. An end-of-interrupt strobe retires the highest in-service vector. A register port reads and writes the task priority and spurious-vector registers, reads the processor priority, and reads the arrays as 32-bit words.

Top module: `irq_prio_core`

## Requirements
- R1: Reads of the arrays return 32-bit words. Word k of an array, bit b, is vector 32k+b. Index 0x10+k reads in-service word k, 0x18+k reads trigger-mode word k, and 0x20+k reads pending word k. Writes to these indices change nothing.
- R2: A delivery strobe sets the pending bit of its vector. It sets that vector's trigger-mode bit when `dlv_level` is 1 and clears it when `dlv_level` is 0.
- R3: The processor priority is readable at index 0x0A. It equals the task priority when the task priority's upper nibble is at least the class of the highest in-service vector. Otherwise it is that class shifted left by 4. An empty in-service array counts as class 0.
- R4: `irq_o` is 1 exactly when all of these hold:
  - bit 8 of the spurious-vector register is 1;
  - some vector is pending;
  - either the processor priority is 0, or the upper nibble of the highest pending vector exceeds the upper nibble of the processor priority.
- R5: An `ack_req` seen in `ACK_IDLE` yields `ack_vld` for exactly one cycle on the next cycle. In the normal case it returns the highest pending vector with `ack_none` = 0, clears that vector's pending bit and sets its in-service bit.
- R6: If the task priority is nonzero and the highest pending vector is less than or equal to it, the acknowledge returns the low 8 bits of the spurious-vector register with `ack_none` = 0. All arrays stay unchanged.
- R7: An acknowledge with bit 8 of the spurious-vector register at 0, or with nothing pending, returns `ack_none` = 1 and changes no array.
- R8: An end-of-interrupt strobe clears only the highest set in-service bit. With no bit set it has no effect.
- R9: A write to index 0x0F keeps only data bits 8:0. A write to index 0x08 stores data bits 7:0 as the task priority. Both registers read back at their indices.
- R10: Reset and `init_i` set the spurious-vector register to 0x0FF and the task priority to 0, and clear all three arrays.
- R11: `irq_o` is derived combinationally from registered state. It reflects a delivery, acknowledge, end-of-interrupt or register write on the cycle after that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous re-initialisation strobe |
| dlv_valid | input | 1 | Vector delivery strobe |
| dlv_vector | input | 8 | Delivered vector number |
| dlv_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| ack_req | input | 1 | Acknowledge request from the core |
| ack_vld | output | 1 | Acknowledge result valid (one cycle) |
| ack_vector | output | 8 | Returned vector or spurious vector |
| ack_none | output | 1 | 1 = no vector was available |
| eoi_i | input | 1 | End-of-interrupt strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The hardest case to reach is a pending vector compared against a processor priority that comes from the in-service array rather than the task priority. Setting that up takes a delivery followed by an acknowledge, and then a second delivery in a different class. The bench sweeps every in-service class against every pending class, and separately every task-priority class against every pending class. Each combination is checked for the priority readback, the request line and the acknowledge outcome. Full 256-vector sweeps fill the arrays, drain them by acknowledge, and retire them by end-of-interrupt. These sweeps confirm the highest-bit ordering at every word boundary.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam logic [7:0] IDX_TPR = 8'h08;
    localparam logic [7:0] IDX_PPR = 8'h0A;
    localparam logic [7:0] IDX_SVR = 8'h0F;
    localparam logic [7:0] IDX_ISR = 8'h10;
    localparam logic [7:0] IDX_TMR = 8'h18;
    localparam logic [7:0] IDX_IRR = 8'h20;

    typedef enum logic [0:0] {
        ACK_IDLE = 1'b0,
        ACK_RESP = 1'b1
    } ack_state_e;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_SPUR  = 2'd1,
        OUT_TAKE  = 2'd2
    } ack_kind_e;
endpackage

// File: rtl/prio_find.sv
module prio_find #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_state.sv
module irq_vec_state #(
    parameter int NVEC = 256,
    parameter int IW   = $clog2(NVEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_i,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    input  logic            set_lvl,
    input  logic            take_en,
    input  logic [IW-1:0]   take_idx,
    input  logic            eoi_en,
    input  logic [IW-1:0]   eoi_idx,
    output logic [NVEC-1:0] irr,
    output logic [NVEC-1:0] isr,
    output logic [NVEC-1:0] tmr
);
    localparam logic [NVEC-1:0] ONE = NVEC'(1);

    logic [NVEC-1:0] set_mask, take_mask, eoi_mask;

    always_comb begin
        set_mask  = set_en  ? (ONE << set_idx)  : '0;
        take_mask = take_en ? (ONE << take_idx) : '0;
        eoi_mask  = eoi_en  ? (ONE << eoi_idx)  : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else if (init_i) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            irr <= (irr & ~take_mask) | set_mask;
            isr <= (isr & ~eoi_mask) | take_mask;
            tmr <= set_lvl ? (tmr | set_mask) : (tmr & ~set_mask);
        end
    end

    p_dlv_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !init_i) |=> (irr[$past(set_idx)] && (tmr[$past(set_idx)] == $past(set_lvl))));

    p_take_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_en && !init_i && !(set_en && set_idx == take_idx))
        |=> (isr[$past(take_idx)] && !irr[$past(take_idx)]));

    p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_en && !take_en && !init_i) |=> ($countones(isr) == $past($countones(isr)) - 1));
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_prio_pkg::*;
#(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          ack_req,
    input  logic          enabled,
    input  logic          irr_any,
    input  logic [IW-1:0] irr_hi,
    input  logic [IW-1:0] tpr,
    input  logic [IW-1:0] spur_vec,
    output logic          take_en,
    output logic          ack_vld,
    output logic [IW-1:0] ack_vector,
    output logic          ack_none
);
    ack_state_e state_q, state_d;
    ack_kind_e  kind;

    always_comb begin
        if (!enabled || !irr_any)
            kind = OUT_NONE;
        else if (tpr != '0 && irr_hi <= tpr)
            kind = OUT_SPUR;
        else
            kind = OUT_TAKE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE: if (ack_req) state_d = ACK_RESP;
            ACK_RESP: state_d = ACK_IDLE;
        endcase
    end

    assign take_en = (state_q == ACK_IDLE) && ack_req && !init_i && (kind == OUT_TAKE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ACK_IDLE;
        else if (init_i)
            state_q <= ACK_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld    <= 1'b0;
            ack_vector <= '0;
            ack_none   <= 1'b0;
        end else if (init_i) begin
            ack_vld    <= 1'b0;
            ack_vector <= '0;
            ack_none   <= 1'b0;
        end else begin
            ack_vld <= (state_q == ACK_IDLE) && ack_req;
            if (state_q == ACK_IDLE && ack_req) begin
                unique case (kind)
                    OUT_NONE: begin ack_none <= 1'b1; ack_vector <= '0;       end
                    OUT_SPUR: begin ack_none <= 1'b0; ack_vector <= spur_vec; end
                    default:  begin ack_none <= 1'b0; ack_vector <= irr_hi;   end
                endcase
            end
        end
    end

    p_ack_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |=> !ack_vld);

    p_ack_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && state_q == ACK_IDLE && !init_i) |=> ack_vld);

    p_none_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && state_q == ACK_IDLE && !init_i && !enabled) |=> ack_none);
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_prio_pkg::*;
#(
    parameter int NVEC   = 256,
    parameter int WORD_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        dlv_valid,
    input  logic [7:0]  dlv_vector,
    input  logic        dlv_level,
    input  logic        ack_req,
    output logic        ack_vld,
    output logic [7:0]  ack_vector,
    output logic        ack_none,
    input  logic        eoi_i,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_o
);
    localparam int IW    = $clog2(NVEC);
    localparam int WORDS = NVEC / WORD_W;
    localparam int WSEL  = $clog2(WORDS);
    localparam int CLS_W = 4;

    logic [IW-1:0]   tpr_q;
    logic [IW:0]     svr_q;
    logic [NVEC-1:0] irr, isr, tmr;
    logic            irr_any, isr_any;
    logic [IW-1:0]   irr_hi, isr_hi;
    logic [IW-1:0]   ppr;
    logic [CLS_W-1:0] isr_cls, tpr_cls;
    logic            take_en;
    logic            enabled;
    logic [WSEL-1:0] word;

    assign enabled = svr_q[IW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tpr_q <= '0;
            svr_q <= {1'b0, {IW{1'b1}}};
        end else if (init_i) begin
            tpr_q <= '0;
            svr_q <= {1'b0, {IW{1'b1}}};
        end else if (reg_wr) begin
            if (reg_addr == IDX_TPR) tpr_q <= reg_wdata[IW-1:0];
            if (reg_addr == IDX_SVR) svr_q <= reg_wdata[IW:0];
        end
    end

    prio_find #(.N(NVEC), .IW(IW)) u_irr_find (.bits(irr), .any(irr_any), .idx(irr_hi));
    prio_find #(.N(NVEC), .IW(IW)) u_isr_find (.bits(isr), .any(isr_any), .idx(isr_hi));

    irq_vec_state #(.NVEC(NVEC), .IW(IW)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (init_i),
        .set_en   (dlv_valid),
        .set_idx  (dlv_vector),
        .set_lvl  (dlv_level),
        .take_en  (take_en),
        .take_idx (irr_hi),
        .eoi_en   (eoi_i && isr_any),
        .eoi_idx  (isr_hi),
        .irr      (irr),
        .isr      (isr),
        .tmr      (tmr)
    );

    irq_ack_fsm #(.IW(IW)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .ack_req    (ack_req),
        .enabled    (enabled),
        .irr_any    (irr_any),
        .irr_hi     (irr_hi),
        .tpr        (tpr_q),
        .spur_vec   (svr_q[IW-1:0]),
        .take_en    (take_en),
        .ack_vld    (ack_vld),
        .ack_vector (ack_vector),
        .ack_none   (ack_none)
    );

    always_comb begin
        tpr_cls = tpr_q[IW-1 -: CLS_W];
        isr_cls = isr_any ? isr_hi[IW-1 -: CLS_W] : '0;
        ppr     = (tpr_cls >= isr_cls) ? tpr_q : {isr_cls, {(IW-CLS_W){1'b0}}};
    end

    assign irq_o = enabled && irr_any &&
                   ((ppr == '0) || (irr_hi[IW-1 -: CLS_W] > ppr[IW-1 -: CLS_W]));

    assign word = reg_addr[WSEL-1:0];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == IDX_TPR)
            reg_rdata = 32'(tpr_q);
        else if (reg_addr == IDX_PPR)
            reg_rdata = 32'(ppr);
        else if (reg_addr == IDX_SVR)
            reg_rdata = 32'(svr_q);
        else if (reg_addr[7:WSEL] == IDX_ISR[7:WSEL])
            reg_rdata = 32'(isr[int'(word)*WORD_W +: WORD_W]);
        else if (reg_addr[7:WSEL] == IDX_TMR[7:WSEL])
            reg_rdata = 32'(tmr[int'(word)*WORD_W +: WORD_W]);
        else if (reg_addr[7:WSEL] == IDX_IRR[7:WSEL])
            reg_rdata = 32'(irr[int'(word)*WORD_W +: WORD_W]);
    end

    p_ppr_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ppr[IW-1 -: CLS_W] >= tpr_q[IW-1 -: CLS_W]);

    p_init_values_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (svr_q == {1'b0, {IW{1'b1}}} && tpr_q == '0 && irr == '0 && isr == '0));

    p_irq_needs_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i || (!dlv_valid && irr == '0)) |=> !irq_o);
endmodule

// File: tb/tb_irq_prio_core.sv
module tb_irq_prio_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        init_i, dlv_valid, dlv_level, ack_req, eoi_i, reg_wr;
    logic [7:0]  dlv_vector, reg_addr;
    logic [31:0] reg_wdata;
    logic        ack_vld, ack_none, irq_o;
    logic [7:0]  ack_vector;
    logic [31:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [255:0] m_irr, m_isr, m_tmr;
    logic [7:0]   m_tpr;
    logic [8:0]   m_sv;

    always #2 clk = ~clk;

    irq_prio_core dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i),
        .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_level(dlv_level),
        .ack_req(ack_req), .ack_vld(ack_vld), .ack_vector(ack_vector), .ack_none(ack_none),
        .eoi_i(eoi_i), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic int hi(logic [255:0] a);
        int r = -1;
        for (int i = 0; i < 256; i++) if (a[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] m_ppr();
        int h  = hi(m_isr);
        int ic = (h < 0) ? 0 : (h >> 4);
        int tc = int'(m_tpr) >> 4;
        return (tc >= ic) ? m_tpr : 8'(ic << 4);
    endfunction

    function automatic logic m_irq();
        int h = hi(m_irr);
        logic [7:0] p;
        if (!m_sv[8] || h < 0) return 1'b0;
        p = m_ppr();
        return (p == 8'd0) || ((h >> 4) > (int'(p) >> 4));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 8'd0; m_sv = 9'h0FF;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 8'h08) m_tpr = d[7:0];
        if (a == 8'h0F) m_sv  = d[8:0];
    endtask

    task automatic deliver(input int v, input bit lvl);
        dlv_valid = 1'b1; dlv_vector = 8'(v); dlv_level = lvl;
        @(negedge clk);
        dlv_valid = 1'b0;
        m_irr[v] = 1'b1;
        m_tmr[v] = lvl;
    endtask

    task automatic eoi();
        int h = hi(m_isr);
        eoi_i = 1'b1;
        @(negedge clk);
        eoi_i = 1'b0;
        if (h >= 0) m_isr[h] = 1'b0;
    endtask

    task automatic do_init();
        init_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0;
        model_clear();
    endtask

    task automatic ack_chk(string tag);
        int h = hi(m_irr);
        bit exp_none = (!m_sv[8] || h < 0);
        bit spur = !exp_none && (m_tpr != 8'd0) && (h <= int'(m_tpr));
        logic [7:0] exp_vec = spur ? m_sv[7:0] : 8'(h);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        chk({tag, " ack_vld"}, 32'(ack_vld), 32'd1);
        chk({tag, " ack_none"}, 32'(ack_none), 32'(exp_none));
        if (!exp_none) chk({tag, " ack_vector"}, 32'(ack_vector), 32'(exp_vec));
        if (!exp_none && !spur) begin
            m_irr[h] = 1'b0;
            m_isr[h] = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic chk_arrays(string tag);
        logic [31:0] d;
        for (int w = 0; w < 8; w++) begin
            rd(8'h10 + 8'(w), d); chk({tag, " isr word"}, d, m_isr[w*32 +: 32]);
            rd(8'h18 + 8'(w), d); chk({tag, " tmr word"}, d, m_tmr[w*32 +: 32]);
            rd(8'h20 + 8'(w), d); chk({tag, " irr word"}, d, m_irr[w*32 +: 32]);
        end
    endtask

    task automatic chk_prio(string tag);
        logic [31:0] d;
        rd(8'h0A, d);
        chk({tag, " R3 ppr"}, d, 32'(m_ppr()));
        chk({tag, " R4 irq_o"}, 32'(irq_o), 32'(m_irq()));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; init_i = 1'b0; dlv_valid = 1'b0; dlv_level = 1'b0; dlv_vector = 8'd0;
        ack_req = 1'b0; eoi_i = 1'b0; reg_wr = 1'b0; reg_addr = 8'd0; reg_wdata = 32'd0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        rd(8'h0F, d); chk("R10 svr after reset", d, 32'h0FF);
        rd(8'h08, d); chk("R10 tpr after reset", d, 32'h0);
        chk_arrays("R10 reset");
        chk("R10 irq_o after reset", 32'(irq_o), 32'd0);
        chk("R10 ack_vld after reset", 32'(ack_vld), 32'd0);

        // R4/R7: disabled controller
        deliver(8'h40, 1'b0);
        chk("R4 irq_o while disabled", 32'(irq_o), 32'd0);
        ack_chk("R7 disabled");
        chk_arrays("R7 disabled unchanged");

        // R9: register widths
        wr(8'h0F, 32'hFFFF_FFFF);
        rd(8'h0F, d); chk("R9 svr 9 bits", d, 32'h1FF);
        wr(8'h08, 32'hABCD_1234);
        rd(8'h08, d); chk("R9 tpr 8 bits", d, 32'h34);

        // R10: init strobe
        do_init();
        rd(8'h0F, d); chk("R10 svr after init", d, 32'h0FF);
        rd(8'h08, d); chk("R10 tpr after init", d, 32'h0);
        chk_arrays("R10 init");

        // R2/R11: fill every vector; irq_o checked one cycle after each delivery
        wr(8'h0F, 32'h100);
        for (int v = 0; v < 256; v++) begin
            deliver(v, (v % 3) == 0);
            chk("R11 irq_o after delivery", 32'(irq_o), 32'(m_irq()));
        end
        chk_arrays("R2 full");

        // R1: array writes ignored
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h1F, 32'h0);
        wr(8'h20, 32'h0);
        wr(8'h27, 32'h0);
        chk_arrays("R1 after writes");

        // R5: drain by acknowledge, highest first
        for (int i = 0; i < 256; i++) begin
            ack_chk("R5 drain");
            chk_prio("R5 drain");
        end
        ack_chk("R7 empty");
        chk_arrays("R5 drained");

        // R8: retire by end-of-interrupt, plus one on an empty array
        for (int i = 0; i < 257; i++) begin
            eoi();
            chk_prio("R8 eoi");
            if (i % 32 == 0) chk_arrays("R8 eoi");
        end
        chk_arrays("R8 empty");

        // R3/R4: in-service class against pending class
        for (int ic = 0; ic < 16; ic++) begin
            for (int pc = 0; pc < 16; pc++) begin
                do_init();
                wr(8'h0F, 32'h1FF);
                deliver(ic * 16 + 7, 1'b0);
                ack_chk("R5 setup");
                deliver(pc * 16 + 9, 1'b1);
                chk_prio("R3 isr class");
                ack_chk("R5 class");
            end
        end

        // R6/R4: task priority class against pending class
        for (int t = 0; t < 16; t++) begin
            for (int pc = 0; pc < 16; pc++) begin
                do_init();
                wr(8'h0F, 32'h1A5);
                wr(8'h08, 32'(t * 16 + 3));
                deliver(pc * 16 + 2, 1'b0);
                chk_prio("R6 tpr class");
                ack_chk("R6 spurious");
                chk_arrays("R6 after ack");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule